// File: doc/BRIEF.md
# Programmable SPI Clock Divider

This block derives the serial clock of an SPI master from the parent clock that runs it. A 32-bit configuration word holds three things. The first is a period count, which sets how many parent cycles one serial-clock period lasts. The second is a high-phase count, which sets how many of those cycles the clock spends in its active level. The third pair is an idle level and a clock-source select bit. Because the period and the active-phase length are programmed on their own, the duty cycle does not have to be 50%. Software usually writes n into the period field and about half of n into the high-phase field.

The transfer engine holds `xfer_en` high for as long as it needs the clock. The block returns `sck` and one-cycle `shift_stb` and `sample_stb` pulses, which mark the leading and trailing edges of every period. Serial data is launched on the leading edge and captured on the trailing edge, so the block supports only the first-edge-launch clock phase. The timing fields are frozen while the clock runs, and a stop request lets the current period finish. As a result, a register write never shortens or stretches a pulse. The 6-bit field at bits 17:12 is accepted on writes and has no effect on the output.

Top module: `spiclk_div`

## Requirements
- R1: After reset, `sck`, `shift_stb`, `sample_stb`, `clk_running` and `clk_src_sel` are all 0.
- R2: A write with `cfg_we` high stores the word in one cycle, using this layout: bits 5:0 period count PC, bits 11:6 high count HC, bit 29 idle level, bit 31 source select.
- R3: While running, one `sck` period lasts T+1 parent cycles, where T = PC. A PC of 0 acts as 1.
- R4: `sck` holds its active level for the first min(HC, T-1)+1 cycles of each period and its idle level for the rest, so every period has at least one idle cycle.
- R5: `shift_stb` is high for exactly the first cycle of each period, which is the cycle where `sck` leaves idle. `sample_stb` is high for exactly the cycle where `sck` returns to idle. The two pulses are never high together.
- R6: When not running, `sck` equals the idle-level bit and both strobes are 0. The active level is the inverse of the idle level.
- R7: After a clock edge that samples `xfer_en` high while stopped, `clk_running` is 1, `sck` is active and `shift_stb` is 1, all in the following cycle.
- R8: When `xfer_en` drops, the current period runs to its last cycle. `clk_running` drops, and `sck` returns to idle, in the cycle after that last cycle.
- R9: PC, HC and the idle level are captured when the clock starts and stay fixed while it runs. A write in the same cycle as the start applies only to the next start.
- R10: The field at bits 17:12 has no effect on `sck` or the strobes.
- R11: The source-select bit reaches `clk_src_sel` in the cycle after the write, whether or not the clock is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word |
| xfer_en | input | 1 | Transfer engine requests the serial clock |
| sck | output | 1 | Serial clock |
| shift_stb | output | 1 | Leading-edge strobe (launch data) |
| sample_stb | output | 1 | Trailing-edge strobe (capture data) |
| clk_running | output | 1 | Serial clock is active |
| clk_src_sel | output | 1 | Clock-source select bit |

## Verification
Two functions can fall in the same cycle: a configuration write and the clock-start capture. The bench raises `cfg_we` and `xfer_en` together. It then expects the first periods to follow the old word exactly, and the new word to appear only after a stop and a restart. A second collision is a stop request arriving in the final cycle of a period. The table walk provokes it on every vector. The bench judges it by requiring `clk_running` and `sck` to drop on the very next cycle with no extra strobe.

// File: rtl/spiclk_pkg.sv
package spiclk_pkg;
  localparam int unsigned CNT_W    = 6;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned PC_LSB   = 0;
  localparam int unsigned HC_LSB   = CNT_W;
  localparam int unsigned IGN_LSB  = 2 * CNT_W;
  localparam int unsigned IDLE_BIT = REG_W - 3;
  localparam int unsigned SRC_BIT  = REG_W - 1;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    cnt_t term;   // last count of a period
    cnt_t hi;     // last count of the active phase
    logic idle;   // idle level of sck
  } timing_t;

  // Clamp the programmed fields: period count 0 acts as 1, active phase
  // always leaves at least one idle cycle.
  function automatic timing_t make_timing(cnt_t pc, cnt_t hc, logic idl);
    timing_t t;
    t.term = (pc == '0) ? cnt_t'(1) : pc;
    t.hi   = (hc >= t.term) ? cnt_t'(t.term - cnt_t'(1)) : hc;
    t.idle = idl;
    return t;
  endfunction
endpackage

// File: rtl/spiclk_rst_sync.sv
module spiclk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q[s] <= 1'b0;
        else if (s == 0) sync_q[s] <= 1'b1;
        else sync_q[s] <= sync_q[(s > 0) ? s - 1 : 0];
      end
    end
  endgenerate

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/spiclk_cfg_reg.sv
module spiclk_cfg_reg
  import spiclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output cnt_t             pc_q,
  output cnt_t             hc_q,
  output logic             idle_q,
  output logic             src_q
);
  cnt_t pc_d, hc_d;
  logic idle_d, src_d;
  logic unused_bits;

  // Bits outside the kept fields, including the ignored 6-bit field (R10).
  assign unused_bits = ^{wr_data[REG_W-2], wr_data[IDLE_BIT-1:IGN_LSB+CNT_W],
                         wr_data[IGN_LSB +: CNT_W]};

  always_comb begin
    pc_d   = pc_q;
    hc_d   = hc_q;
    idle_d = idle_q;
    src_d  = src_q;
    if (wr_en) begin
      pc_d   = wr_data[PC_LSB +: CNT_W];
      hc_d   = wr_data[HC_LSB +: CNT_W];
      idle_d = wr_data[IDLE_BIT];
      src_d  = wr_data[SRC_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      hc_q   <= '0;
      idle_q <= 1'b0;
      src_q  <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      hc_q   <= hc_d;
      idle_q <= idle_d;
      src_q  <= src_d;
    end
  end

  assert_src_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> (src_q == $past(wr_data[SRC_BIT])));
endmodule

// File: rtl/spiclk_shadow.sv
module spiclk_shadow
  import spiclk_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    running,
  input  timing_t live,
  output timing_t eff
);
  timing_t shadow_q, shadow_d;

  always_comb begin
    shadow_d = shadow_q;
    if (!running) shadow_d = live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadow_q <= '0;
    else        shadow_q <= shadow_d;
  end

  // While stopped the live fields drive the next start; while running the
  // captured copy is used.
  assign eff = running ? shadow_q : live;

  assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running)) |-> $stable(shadow_q));

  assert_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (shadow_q.hi < shadow_q.term));
endmodule

// File: rtl/spiclk_phase_ctr.sv
module spiclk_phase_ctr
  import spiclk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run_req,
  input  cnt_t term,
  output logic act_q,
  output cnt_t cnt_q,
  output logic act_d,
  output cnt_t cnt_d
);
  logic at_end;

  assign at_end = (cnt_q == term);

  always_comb begin
    if (!act_q) begin
      act_d = run_req;
      cnt_d = '0;
    end else begin
      act_d = run_req || !at_end;
      cnt_d = at_end ? '0 : cnt_t'(cnt_q + cnt_t'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (cnt_q <= term));

  assert_start_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> (cnt_q == '0));

  assert_stop_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_q) |-> ($past(cnt_q) == $past(term)));
endmodule

// File: rtl/spiclk_wave.sv
module spiclk_wave
  import spiclk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic act_d,
  input  cnt_t cnt_d,
  input  cnt_t hi,
  input  logic idle,
  output logic sck_q,
  output logic shift_q,
  output logic sample_q
);
  logic sck_d, shift_d, sample_d;
  logic [CNT_W:0] fall_at;

  assign fall_at = {1'b0, hi} + 1'b1;

  always_comb begin
    sck_d    = idle;
    shift_d  = 1'b0;
    sample_d = 1'b0;
    if (act_d) begin
      sck_d    = (cnt_d <= hi) ? ~idle : idle;
      shift_d  = (cnt_d == '0);
      sample_d = ({1'b0, cnt_d} == fall_at);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= 1'b0;
      shift_q  <= 1'b0;
      sample_q <= 1'b0;
    end else begin
      sck_q    <= sck_d;
      shift_q  <= shift_d;
      sample_q <= sample_d;
    end
  end

  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_q && sample_q));

  assert_shift_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_q |-> (sck_q != $past(sck_q)));

  assert_sample_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_q |-> (sck_q != $past(sck_q)));
endmodule

// File: rtl/spiclk_div.sv
module spiclk_div
  import spiclk_pkg::*;
(
  input  logic             clk,
  input  logic             arst_n,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic             xfer_en,
  output logic             sck,
  output logic             shift_stb,
  output logic             sample_stb,
  output logic             clk_running,
  output logic             clk_src_sel
);
  logic    rst_n;
  cnt_t    pc_q, hc_q;
  logic    idle_q;
  timing_t live, eff;
  logic    act_q, act_d;
  cnt_t    cnt_q, cnt_d;

  spiclk_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(arst_n), .rst_n(rst_n)
  );

  spiclk_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_data(cfg_wdata),
    .pc_q(pc_q), .hc_q(hc_q), .idle_q(idle_q), .src_q(clk_src_sel)
  );

  assign live = make_timing(pc_q, hc_q, idle_q);

  spiclk_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .running(act_q), .live(live), .eff(eff)
  );

  spiclk_phase_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .run_req(xfer_en), .term(eff.term),
    .act_q(act_q), .cnt_q(cnt_q), .act_d(act_d), .cnt_d(cnt_d)
  );

  spiclk_wave u_wave (
    .clk(clk), .rst_n(rst_n), .act_d(act_d), .cnt_d(cnt_d),
    .hi(eff.hi), .idle(eff.idle),
    .sck_q(sck), .shift_q(shift_stb), .sample_q(sample_stb)
  );

  assign clk_running = act_q;

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_running |-> (!shift_stb && !sample_stb));
endmodule

// File: tb/sim_spiclk_div.sv
module sim_spiclk_div;
  logic        clk = 1'b0;
  logic        arst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        xfer_en = 1'b0;
  logic        sck, shift_stb, sample_stb, clk_running, clk_src_sel;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spiclk_div u0 (
    .clk(clk), .arst_n(arst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .xfer_en(xfer_en), .sck(sck), .shift_stb(shift_stb),
    .sample_stb(sample_stb), .clk_running(clk_running),
    .clk_src_sel(clk_src_sel)
  );

  typedef struct packed {
    logic [5:0] pc;
    logic [5:0] hc;
    logic [5:0] ign;
    logic       idl;
    logic [7:0] per;
    logic [7:0] act;
  } vec_t;

  // period = max(pc,1)+1 ; active = min(hc, max(pc,1)-1)+1
  localparam vec_t VEC [8] = '{
    '{pc:6'd1,  hc:6'd0,  ign:6'd1,  idl:1'b0, per:8'd2,  act:8'd1},
    '{pc:6'd0,  hc:6'd0,  ign:6'd0,  idl:1'b0, per:8'd2,  act:8'd1},   // R3 zero
    '{pc:6'd5,  hc:6'd2,  ign:6'd5,  idl:1'b0, per:8'd6,  act:8'd3},
    '{pc:6'd6,  hc:6'd1,  ign:6'd6,  idl:1'b1, per:8'd7,  act:8'd2},   // R6 high idle
    '{pc:6'd4,  hc:6'd9,  ign:6'd4,  idl:1'b0, per:8'd5,  act:8'd4},   // R4 clamp
    '{pc:6'd63, hc:6'd31, ign:6'd63, idl:1'b0, per:8'd64, act:8'd32},
    '{pc:6'd3,  hc:6'd1,  ign:6'd42, idl:1'b1, per:8'd4,  act:8'd2},   // R10
    '{pc:6'd2,  hc:6'd2,  ign:6'd2,  idl:1'b0, per:8'd3,  act:8'd2}    // R4 clamp
  };

  function automatic logic [31:0] mk(input logic [5:0] pc, input logic [5:0] hc,
                                     input logic [5:0] ign, input logic idl,
                                     input logic src);
    return {src, 1'b0, idl, 11'b0, ign, hc, pc};
  endfunction

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, got, exp, $time);
    end
  endtask

  task automatic write(input logic [31:0] w);
    cfg_we = 1'b1;
    cfg_wdata = w;
    tick();
    cfg_we = 1'b0;
  endtask

  // packed view {running, sck, shift, sample}
  task automatic exp_cycle(input string req, input int idx, input int per,
                           input int act, input logic idl);
    logic s;
    s = (idx < act) ? ~idl : idl;
    chk(req, {28'd0, clk_running, sck, shift_stb, sample_stb},
        {28'd0, 1'b1, s, (idx == 0), (idx == act)});
    if (per < 0) n_fail++;
  endtask

  task automatic exp_idle(input string req, input logic idl);
    chk(req, {28'd0, clk_running, sck, shift_stb, sample_stb},
        {28'd0, 1'b0, idl, 1'b0, 1'b0});
  endtask

  // Run np periods from stopped, ending with a stop requested in the last cycle.
  task automatic run_periods(input string req, input int per, input int act,
                             input logic idl, input int np);
    xfer_en = 1'b1;
    tick();
    for (int i = 0; i < np * per; i++) begin
      if (i > 0) tick();
      exp_cycle(req, i % per, per, act, idl);
    end
    xfer_en = 1'b0;
    tick();
    exp_idle("R8 stop at period end", idl);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R7: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state, during and after reset
    tick(); tick();
    chk("R1 during reset", {27'd0, clk_running, sck, shift_stb, sample_stb, clk_src_sel}, '0);
    arst_n = 1'b1;
    tick(); tick(); tick();
    chk("R1 after release", {27'd0, clk_running, sck, shift_stb, sample_stb, clk_src_sel}, '0);

    // Table walk: R2 R3 R4 R5 R6 R7 R8 R10
    for (int v = 0; v < 8; v++) begin
      write(mk(VEC[v].pc, VEC[v].hc, VEC[v].ign, VEC[v].idl, 1'b0));
      tick();
      exp_idle("R6 idle level", VEC[v].idl);
      run_periods((VEC[v].ign != VEC[v].pc) ? "R10 ignored field" : "R2 R3 R4 R5 R7",
                  int'(VEC[v].per), int'(VEC[v].act), VEC[v].idl, 2);
    end

    // R8: stop requested mid-period; the period completes
    write(mk(6'd5, 6'd2, 6'd0, 1'b0, 1'b0));
    tick();
    xfer_en = 1'b1;
    tick();
    exp_cycle("R8 before stop", 0, 6, 3, 1'b0);
    tick();
    exp_cycle("R8 before stop", 1, 6, 3, 1'b0);
    xfer_en = 1'b0;
    for (int i = 2; i < 6; i++) begin
      tick();
      exp_cycle("R8 finish period", i, 6, 3, 1'b0);
    end
    tick();
    exp_idle("R8 stopped", 1'b0);

    // R9 + R11: write during a run is deferred; source bit is not
    write(mk(6'd3, 6'd1, 6'd0, 1'b0, 1'b0));
    tick();
    xfer_en = 1'b1;
    tick();
    exp_cycle("R9 old timing", 0, 4, 2, 1'b0);
    write(mk(6'd7, 6'd5, 6'd0, 1'b1, 1'b1));
    chk("R11 source select while running", {31'd0, clk_src_sel}, 32'd1);
    exp_cycle("R9 old timing", 1, 4, 2, 1'b0);
    for (int i = 2; i < 8; i++) begin
      tick();
      exp_cycle("R9 old timing", i % 4, 4, 2, 1'b0);
    end
    xfer_en = 1'b0;
    tick();
    exp_idle("R9 stop with old idle", 1'b0);
    tick();
    exp_idle("R9 new idle level", 1'b1);
    run_periods("R9 new timing", 8, 6, 1'b1, 1);

    // R9 collision: write in the same cycle as the start
    write(mk(6'd2, 6'd0, 6'd0, 1'b0, 1'b0));
    chk("R11 source cleared", {31'd0, clk_src_sel}, 32'd0);
    tick();
    cfg_we = 1'b1;
    cfg_wdata = mk(6'd5, 6'd2, 6'd0, 1'b0, 1'b0);
    xfer_en = 1'b1;
    tick();
    cfg_we = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (i > 0) tick();
      exp_cycle("R9 start collision", i % 3, 3, 1, 1'b0);
    end
    xfer_en = 1'b0;
    tick();
    exp_idle("R8 stop after collision", 1'b0);
    run_periods("R9 applied on restart", 6, 3, 1'b0, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule